// File: doc/BRIEF.md
# Byte-Serial Status Reporter

The block reports a small set of status flags to a downstream collector over an 8-bit address/data bus. Each report is a short message. The first byte is a fixed status-register address. The payload bytes follow it, and the flags sit in the low bits of the first payload byte. The reporter raises a request and puts the address byte on the bus. It then waits for the collector to acknowledge that byte with a one-cycle start pulse. After the acknowledge, it streams the remaining bytes on back-to-back cycles. The request is dropped during the final byte, which marks the end of the message.

A control byte written through a command strobe sets how reports are produced. The reporter can be switched off. It can send a single report of the present flags. It can also run automatically, in which case it reports once when the mode is enabled and again every time the flags differ from the value last sent. A flag change seen while a message is in flight is remembered and sent as soon as that message ends, even if the flags have since reverted.

The only form of back-pressure is the start acknowledge. While the collector withholds it, the address byte and the request stay frozen. A start pulse at any other time does nothing. Once the address is accepted, the payload cannot be stalled.

Top module: `stat_reporter`

## Requirements
- R1: One cycle after a clock edge with `rst` high, `rpt_req` is 0 and `rpt_ad` is 0.
- R2: Every message begins with a cycle where `rpt_req` is 1 and `rpt_ad` equals the parameter `STAT_ADDR` (default 8'h74).
- R3: While the address byte is unacknowledged, `rpt_req` and `rpt_ad` hold unchanged. A `rpt_start` pulse while no address byte is waiting causes no message.
- R4: In the cycle after `rpt_start` is sampled high during the address byte, the payload byte is on the bus with `rpt_req` at 0. In the cycle after that, `rpt_ad` is 0 and `rpt_req` is 0.
- R5: Control codes are in `ctrl_byte[1:0]`, and bits 7:2 are ignored. Code 00 (off) and code 10 (reserved, treated as off) start no new messages and cancel any pending single report.
- R6: Code 01 sends exactly one message carrying the flags present when it starts. Later flag changes send nothing.
- R7: Code 11 sends one message at once. After that it sends one message each time `stat_flags` differs from the payload last sent, and none while the flags match it.
- R8: A flag change during a message in flight (code 11) causes one further message after that one ends, even if the flags returned to the sent value meanwhile.
- R9: The payload byte is {6'b0, stat_flags} as sampled at the clock edge that launched the message: bit 1 is frame-finished and bit 0 is busy. Changes made after launch do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | One-cycle write strobe for the control byte |
| ctrl_byte | input | CTRL_W (8) | Control value; bits 1:0 select the reporting mode |
| stat_flags | input | FLAG_W (2) | Status payload: bit 1 frame finished, bit 0 busy |
| rpt_ad | output | BUS_W (8) | Message byte: address first, then payload |
| rpt_req | output | 1 | High while more bytes follow; low on the last byte |
| rpt_start | input | 1 | Downstream acknowledge of the address byte |

## Verification
The hardest case to reach is a flag change that lands inside a message and then disappears before the message ends (R8), together with the payload snapshot (R9). The bench stretches the address phase by having its responder hold back the start acknowledge for several cycles. During that window it pulses the flags away from the launched value and back. It also moves them to a new value and leaves them there. It then expects two messages: the first carries the launch-time snapshot and the second carries the flags present when the reporter next goes idle.

// File: rtl/stat_rpt_pkg.sv
`timescale 1ns/1ps
package stat_rpt_pkg;

  typedef enum logic [1:0] {
    RPT_OFF  = 2'b00,
    RPT_ONCE = 2'b01,
    RPT_RSV  = 2'b10,
    RPT_AUTO = 2'b11
  } rpt_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_HOLD,
    SH_SEND
  } sh_state_e;

  // address byte plus enough bytes to carry the payload
  function automatic int msg_bytes(input int flag_w, input int bus_w);
    return 1 + (flag_w + bus_w - 1) / bus_w;
  endfunction

endpackage

// File: rtl/stat_rpt_ctrl.sv
`timescale 1ns/1ps
module stat_rpt_ctrl
  import stat_rpt_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic              launch,
  output logic              auto_en,
  output logic              once_pend
);

  rpt_mode_e mode_q;
  rpt_mode_e mode_d;
  logic      once_q;
  logic      unused_ctrl_hi;

  assign mode_d         = rpt_mode_e'(ctrl_byte[1:0]);
  assign unused_ctrl_hi = ^ctrl_byte[CTRL_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RPT_OFF;
      once_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= mode_d;
      once_q <= (mode_d == RPT_ONCE) || (mode_d == RPT_AUTO);
    end else if (launch) begin
      once_q <= 1'b0;
    end
  end

  assign auto_en   = (mode_q == RPT_AUTO);
  assign once_pend = once_q;

endmodule

// File: rtl/stat_rpt_trigger.sv
`timescale 1ns/1ps
module stat_rpt_trigger #(
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags,
  input  logic              auto_en,
  input  logic              launch,
  output logic [FLAG_W-1:0] snap,
  output logic              chg_want
);

  logic [FLAG_W-1:0] snap_q;
  logic              chg_q;
  logic              differs;

  assign differs = (flags != snap_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
    end else if (launch) begin
      snap_q <= flags;
    end
  end

  // sticky record of any change seen while a message is busy
  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= 1'b0;
    end else if (!auto_en || launch) begin
      chg_q <= 1'b0;
    end else if (differs) begin
      chg_q <= 1'b1;
    end
  end

  assign snap     = snap_q;
  assign chg_want = auto_en && (chg_q || differs);

endmodule

// File: rtl/stat_rpt_shifter.sv
`timescale 1ns/1ps
module stat_rpt_shifter
  import stat_rpt_pkg::*;
#(
  parameter int               FLAG_W    = 2,
  parameter int               BUS_W     = 8,
  parameter logic [BUS_W-1:0] STAT_ADDR = 8'h74
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              want,
  input  logic              start_ack,
  input  logic [FLAG_W-1:0] snap,
  output logic              launch,
  output logic [BUS_W-1:0]  bus_ad,
  output logic              bus_req
);

  localparam int NB    = msg_bytes(FLAG_W, BUS_W);
  localparam int PAD_W = (NB - 1) * BUS_W;
  localparam int IDX_W = (NB > 2) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(NB - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 2);
  localparam logic             MULTI    = (NB > 2);

  sh_state_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic [BUS_W-1:0] ad_q;
  logic             req_q;
  logic [PAD_W-1:0] pad;
  logic [BUS_W-1:0] body [NB];

  always_comb begin
    pad              = '0;
    pad[FLAG_W-1:0]  = snap;
  end

  for (genvar g = 0; g < NB - 1; g++) begin : g_body
    assign body[g] = pad[g*BUS_W +: BUS_W];
  end
  assign body[NB-1] = '0;

  assign launch = (st_q == SH_IDLE) && want;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SH_IDLE;
      idx_q <= '0;
      ad_q  <= '0;
      req_q <= 1'b0;
    end else begin
      case (st_q)
        SH_IDLE: begin
          if (want) begin
            st_q  <= SH_HOLD;
            ad_q  <= STAT_ADDR;
            req_q <= 1'b1;
            idx_q <= '0;
          end
        end
        SH_HOLD: begin
          if (start_ack) begin
            st_q  <= SH_SEND;
            ad_q  <= body[0];
            req_q <= MULTI;
            idx_q <= IDX_W'(1);
          end
        end
        SH_SEND: begin
          if (idx_q == IDX_DONE) begin
            st_q  <= SH_IDLE;
            ad_q  <= '0;
            req_q <= 1'b0;
            idx_q <= '0;
          end else begin
            ad_q  <= body[idx_q];
            req_q <= (idx_q != IDX_LAST);
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: begin
          st_q  <= SH_IDLE;
          ad_q  <= '0;
          req_q <= 1'b0;
        end
      endcase
    end
  end

  assign bus_ad  = ad_q;
  assign bus_req = req_q;

endmodule

// File: rtl/stat_reporter.sv
`timescale 1ns/1ps
module stat_reporter #(
  parameter int               FLAG_W    = 2,
  parameter int               BUS_W     = 8,
  parameter int               CTRL_W    = 8,
  parameter logic [BUS_W-1:0] STAT_ADDR = 8'h74
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic [FLAG_W-1:0] stat_flags,
  output logic [BUS_W-1:0]  rpt_ad,
  output logic              rpt_req,
  input  logic              rpt_start
);

  logic              launch;
  logic              auto_en;
  logic              once_pend;
  logic              chg_want;
  logic [FLAG_W-1:0] snap;

  stat_rpt_ctrl #(.CTRL_W(CTRL_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_byte (ctrl_byte),
    .launch    (launch),
    .auto_en   (auto_en),
    .once_pend (once_pend)
  );

  stat_rpt_trigger #(.FLAG_W(FLAG_W)) trig_i (
    .clk      (clk),
    .rst      (rst),
    .flags    (stat_flags),
    .auto_en  (auto_en),
    .launch   (launch),
    .snap     (snap),
    .chg_want (chg_want)
  );

  stat_rpt_shifter #(
    .FLAG_W    (FLAG_W),
    .BUS_W     (BUS_W),
    .STAT_ADDR (STAT_ADDR)
  ) shift_i (
    .clk       (clk),
    .rst       (rst),
    .want      (once_pend || chg_want),
    .start_ack (rpt_start),
    .snap      (snap),
    .launch    (launch),
    .bus_ad    (rpt_ad),
    .bus_req   (rpt_req)
  );

endmodule

// File: rtl/stat_reporter_chk.sv
`timescale 1ns/1ps
module stat_reporter_chk
  import stat_rpt_pkg::*;
#(
  parameter int               FLAG_W    = 2,
  parameter int               BUS_W     = 8,
  parameter int               CTRL_W    = 8,
  parameter logic [BUS_W-1:0] STAT_ADDR = 8'h74
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_byte,
  input logic [BUS_W-1:0]  rpt_ad,
  input logic              rpt_req,
  input logic              rpt_start
);

  localparam logic TWO_BYTE = (msg_bytes(FLAG_W, BUS_W) == 2);

  logic rst_d;
  logic off_q;
  logic unused_hi;

  assign unused_hi = ^ctrl_byte[CTRL_W-1:2];

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst) off_q <= 1'b1;
    else if (ctrl_wr) off_q <= !ctrl_byte[0];
  end

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_idle_chk: assert (!rpt_req && rpt_ad == '0)
        else $error("bus not idle after reset");
    end
  end

  // R2
  first_byte_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rpt_req) |-> rpt_ad == STAT_ADDR);

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (TWO_BYTE && rpt_req && !rpt_start) |=> rpt_req && $stable(rpt_ad));

  // R4
  last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (TWO_BYTE && rpt_req && rpt_start) |=> !rpt_req);

  // R4
  gap_after_msg_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rpt_req) |=> !rpt_req && rpt_ad == '0);

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (off_q && !rpt_req && !ctrl_wr) |=> !rpt_req);

endmodule

bind stat_reporter stat_reporter_chk #(
  .FLAG_W    (FLAG_W),
  .BUS_W     (BUS_W),
  .CTRL_W    (CTRL_W),
  .STAT_ADDR (STAT_ADDR)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctrl_wr   (ctrl_wr),
  .ctrl_byte (ctrl_byte),
  .rpt_ad    (rpt_ad),
  .rpt_req   (rpt_req),
  .rpt_start (rpt_start)
);

// File: tb/stat_reporter_tb_top.sv
`timescale 1ns/1ps
module stat_reporter_tb_top;

  localparam logic [7:0] ADDR = 8'h74;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic [1:0] flags = 2'b00;
  logic       resp_start = 1'b0;
  logic       spur_start = 1'b0;
  logic       rpt_start;
  logic [7:0] rpt_ad;
  logic       rpt_req;

  int checks = 0;
  int fails = 0;
  int msg_cnt = 0;
  int ack_delay = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  assign rpt_start = resp_start | spur_start;

  always #2.5 clk = ~clk;

  stat_reporter dut_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_byte  (ctrl_byte),
    .stat_flags (flags),
    .rpt_ad     (rpt_ad),
    .rpt_req    (rpt_req),
    .rpt_start  (rpt_start)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_msg(input logic [1:0] f);
    exp_q.push_back({6'b0, f});
  endtask

  task automatic wr_ctrl(input logic [1:0] code);
    @(negedge clk);
    ctrl_wr   = 1'b1;
    ctrl_byte = {6'b101100, code};
    @(negedge clk);
    ctrl_wr   = 1'b0;
    ctrl_byte = 8'h00;
  endtask

  task automatic set_flags(input logic [1:0] v);
    @(negedge clk);
    flags = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    cycles(3);
  endtask

  // monitor and responder: acknowledges the address byte, checks the message
  initial begin : monitor
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (!rst && rpt_req) begin
        chk(rpt_ad == ADDR, "R2 address byte first", rpt_ad, ADDR);
        for (int i = 0; i < ack_delay; i++) begin
          @(negedge clk);
          chk(rpt_req && rpt_ad == ADDR, "R3 held until start", {rpt_req, rpt_ad}, {1'b1, ADDR});
        end
        resp_start = 1'b1;
        @(negedge clk);
        resp_start = 1'b0;
        chk(!rpt_req, "R4 request low on last byte", rpt_req, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected message", rpt_ad, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rpt_ad == e, "R9 payload byte", rpt_ad, e);
        end
        @(negedge clk);
        chk(!rpt_req && rpt_ad == 8'h00, "R4 bus idle after message", {rpt_req, rpt_ad}, 0);
        msg_cnt++;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d messages expected completion", msg_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    cycles(3);
    chk(!rpt_req && rpt_ad == 8'h00, "R1 outputs during reset", {rpt_req, rpt_ad}, 0);
    @(negedge clk);
    rst = 1'b0;
    chk(!rpt_req && rpt_ad == 8'h00, "R1 reset state", {rpt_req, rpt_ad}, 0);

    // R5 off after reset: flag changes send nothing
    set_flags(2'b11);
    cycles(8);
    chk(msg_cnt == 0, "R5 off mode silent", msg_cnt, 0);

    // R5 reserved code acts as off
    wr_ctrl(2'b10);
    set_flags(2'b01);
    cycles(8);
    chk(msg_cnt == 0, "R5 reserved code silent", msg_cnt, 0);

    // R6 single report
    set_flags(2'b10);
    expect_msg(2'b10);
    wr_ctrl(2'b01);
    drain();
    chk(msg_cnt == 1, "R6 one message", msg_cnt, 1);
    set_flags(2'b01);
    cycles(10);
    chk(msg_cnt == 1, "R6 no repeat on change", msg_cnt, 1);

    // R7 automatic mode
    expect_msg(2'b01);
    wr_ctrl(2'b11);
    drain();
    chk(msg_cnt == 2, "R7 immediate message", msg_cnt, 2);
    expect_msg(2'b11);
    set_flags(2'b11);
    drain();
    expect_msg(2'b00);
    set_flags(2'b00);
    drain();
    cycles(10);
    chk(msg_cnt == 4, "R7 one message per change", msg_cnt, 4);

    // R3 start pulses while nothing waits
    spur_start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!rpt_req && rpt_ad == 8'h00, "R3 stray start ignored", {rpt_req, rpt_ad}, 0);
    end
    spur_start = 1'b0;
    chk(msg_cnt == 4, "R3 stray start no message", msg_cnt, 4);

    // R3 back-pressure on the address byte
    ack_delay = 6;
    expect_msg(2'b10);
    set_flags(2'b10);
    drain();

    // R8 change that reverts during flight still sends once more
    expect_msg(2'b01);
    expect_msg(2'b01);
    set_flags(2'b01);
    while (!rpt_req) @(negedge clk);
    flags = 2'b10;
    @(negedge clk);
    flags = 2'b01;
    drain();
    chk(msg_cnt == 7, "R8 latched change resent", msg_cnt, 7);

    // R9 snapshot at launch, new value follows
    expect_msg(2'b00);
    expect_msg(2'b11);
    set_flags(2'b00);
    while (!rpt_req) @(negedge clk);
    flags = 2'b11;
    drain();
    chk(msg_cnt == 9, "R9 snapshot then update", msg_cnt, 9);
    ack_delay = 0;

    // R5 writing off stops automatic reports
    wr_ctrl(2'b00);
    set_flags(2'b10);
    cycles(10);
    chk(msg_cnt == 9, "R5 off stops reports", msg_cnt, 9);
    chk(exp_q.size() == 0, "R7 all expected messages seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule